// File: doc/BRIEF.md
# Command stream decoder

This block sits behind a channel command FIFO and turns its stream of 32-bit words into register writes for a client unit. Each header word carries a 4-bit opcode in bits 31:28. The block decides from that opcode how many payload words follow, and it consumes exactly that many. While it does so it keeps track of the current class and register offset, and it emits one write (class, offset, data) for every payload word that carries register data.

Restart, gather-fetch and lock requests, as well as malformed headers, leave the block as single-cycle pulses on side-band outputs. No write is produced for them. The command input and the write output each use a valid/ready handshake. Input words are taken only when the registered write slot is free, so a stalled consumer stops the stream without losing any word.

The controller is a five-state machine:

| State | Role |
|-------|------|
| `ST_HEADER` | Waits for and decodes a header. |
| `ST_INCR` | Consumes incrementing payload words. |
| `ST_NONINCR` | Consumes payload words at a fixed offset. |
| `ST_MASKED` | Consumes payload words for a masked set-class or masked write. |
| `ST_GATHER` | Takes the single fetch-address word of a gather. |

Transitions out of `ST_HEADER`, taken when a header is accepted:

| Header | Next state |
|--------|------------|
| Set-class with a non-zero mask | `ST_MASKED` |
| Masked write with a non-zero mask | `ST_MASKED` |
| Incrementing write with a non-zero count | `ST_INCR` |
| Non-incrementing write with a non-zero count | `ST_NONINCR` |
| Gather | `ST_GATHER` |
| Any other header | stays in `ST_HEADER` |

Transitions back to `ST_HEADER`:

| From | When |
|------|------|
| `ST_INCR` or `ST_NONINCR` | The last counted word is accepted. |
| `ST_MASKED` | The word for the highest set mask bit is accepted. |
| `ST_GATHER` | The address word is accepted. |

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset there is no write pending and no side-band pulse, and the state is ST_HEADER. The current class and offset are 0, so the payload of an incrementing write issued before any set-class is written with class 0.
- R2: Set-class, opcode 0, takes its class from bits 15:6, a base offset from bits 27:16 and a 6-bit mask from bits 5:0. The new class applies to its own payload. One payload word follows per set mask bit, written in ascending bit order to base + bit index. A zero mask only changes the class.
- R3: Incrementing write, opcode 1, takes its start offset from bits 27:16 and a word count from bits 15:0. Payload word i is written to start + i, modulo 4096.
- R4: Non-incrementing write, opcode 2, uses the same fields as opcode 1. Every payload word is written to the start offset.
- R5: Masked write, opcode 3, takes a base offset from bits 27:16 and a 16-bit mask from bits 15:0. One payload word follows per set bit, written in ascending bit order to base + bit index.
- R6: Immediate write, opcode 4, has no payload. It produces one write at the offset in bits 27:16, with data equal to bits 15:0 zero-extended, in the current class.
- R7: Restart, opcode 5, has no payload. It pulses restart_valid with restart_addr equal to the header shifted left by 4, keeping the low 32 bits.
- R8: Gather, opcode 6, is followed by exactly one address word. When that word is taken, gather_valid pulses with the address, the offset from bits 27:16, insert from bit 15, type from bit 14 and the count from bits 13:0. No write is produced.
- R9: Extend, opcode 14, selects a sub-operation in bits 27:24 and a lock index in bits 7:0. Sub-operation 0 pulses lock_valid with lock_release=0, and sub-operation 1 pulses lock_valid with lock_release=1. Any other sub-operation pulses ext_unknown. None of them has a payload.
- R10: An incrementing, non-incrementing or masked header whose count or mask is zero is consumed on its own, and the next word is decoded as a header.
- R11: Opcodes 7 to 13 and 15 pulse bad_opcode for one cycle and are consumed with no payload.
- R12: While wr_valid is high and wr_ready is low, in_ready is low and the class, offset and data of the write are held.
- R13: A write appears on the output in the cycle after its word is accepted. A side-band pulse appears in the cycle after its word is accepted and lasts one cycle. At most one side-band pulse is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A command word is offered |
| in_ready | output | 1 | The offered word is taken on this edge |
| in_word | input | 32 | Command word |
| wr_valid | output | 1 | A register write is pending |
| wr_ready | input | 1 | The client takes the pending write |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| restart_valid | output | 1 | Restart request pulse |
| restart_addr | output | 32 | New fetch address |
| gather_valid | output | 1 | Gather request pulse |
| gather_offset | output | 12 | Gather offset field |
| gather_insert | output | 1 | Gather insert flag |
| gather_type | output | 1 | Gather type flag |
| gather_count | output | 14 | Gather word count |
| gather_addr | output | 32 | Gather fetch address |
| lock_valid | output | 1 | Lock request pulse |
| lock_release | output | 1 | 0 for acquire, 1 for release |
| lock_index | output | 8 | Lock index |
| ext_unknown | output | 1 | Pulse for an unrecognized extend sub-operation |
| bad_opcode | output | 1 | Pulse for an unused opcode |

## Verification
Write headers of every kind are sent with distinct data per word, so the scoreboard tells apart payload ordering, offset stepping and class selection. An incrementing run from 0xFFE separates offset wrap from saturation. A sparse mask, 16'h8421, and a full 16-bit mask separate the ascending walk and its termination from a count-based one. A zero-mask set-class followed by an immediate write shows that the class changes without any payload. Zero-count, zero-mask and unused-opcode headers, each followed by an immediate write, show that the following word is decoded as a header. A phase with random write back-pressure checks that held writes stay stable and that no input word is lost.

// File: rtl/cmdsd_pkg.sv
package cmdsd_pkg;
    localparam int WORD_W  = 32;
    localparam int CLASS_W = 10;
    localparam int OFF_W   = 12;
    localparam int CNT_W   = 16;
    localparam int MASK_W  = 16;
    localparam int SMASK_W = 6;
    localparam int GCNT_W  = 14;
    localparam int LOCK_W  = 8;
    localparam int SUB_W   = 4;
    localparam int IDX_W   = $clog2(MASK_W);

    localparam logic [3:0] OPC_SETCL   = 4'd0;
    localparam logic [3:0] OPC_INCR    = 4'd1;
    localparam logic [3:0] OPC_NONINCR = 4'd2;
    localparam logic [3:0] OPC_MASK    = 4'd3;
    localparam logic [3:0] OPC_IMM     = 4'd4;
    localparam logic [3:0] OPC_RESTART = 4'd5;
    localparam logic [3:0] OPC_GATHER  = 4'd6;
    localparam logic [3:0] OPC_EXTEND  = 4'd14;

    localparam logic [SUB_W-1:0] SUB_ACQUIRE = 4'd0;
    localparam logic [SUB_W-1:0] SUB_RELEASE = 4'd1;

    typedef enum logic [2:0] {
        ST_HEADER,
        ST_INCR,
        ST_NONINCR,
        ST_MASKED,
        ST_GATHER
    } state_e;

    typedef struct packed {
        logic [3:0]         opc;
        logic [CLASS_W-1:0] cls;
        logic [OFF_W-1:0]   off;
        logic [CNT_W-1:0]   cnt;
        logic [MASK_W-1:0]  mask;
        logic [SMASK_W-1:0] smask;
        logic               g_ins;
        logic               g_type;
        logic [GCNT_W-1:0]  g_cnt;
        logic [SUB_W-1:0]   sub;
        logic [LOCK_W-1:0]  lock;
    } hdr_t;
endpackage

// File: rtl/cmdsd_hdr_split.sv
module cmdsd_hdr_split
    import cmdsd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);
    always_comb begin
        hdr.opc    = word[31:28];
        hdr.off    = word[27:16];
        hdr.cls    = word[15:6];
        hdr.smask  = word[5:0];
        hdr.cnt    = word[15:0];
        hdr.mask   = word[15:0];
        hdr.g_ins  = word[15];
        hdr.g_type = word[14];
        hdr.g_cnt  = word[13:0];
        hdr.sub    = word[27:24];
        hdr.lock   = word[7:0];
    end
endmodule

// File: rtl/cmdsd_mask_walk.sv
module cmdsd_mask_walk #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);
    // Lowest set bit: scan from the top so the lowest index wins.
    always_comb begin
        idx = '0;
        for (int b = W - 1; b >= 0; b--) begin
            if (mask[b]) idx = IW'(b);
        end
        rest = mask & (mask - W'(1));
    end
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmdsd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [CLASS_W-1:0]  wr_class,
    output logic [OFF_W-1:0]    wr_offset,
    output logic [WORD_W-1:0]   wr_data,
    output logic                restart_valid,
    output logic [WORD_W-1:0]   restart_addr,
    output logic                gather_valid,
    output logic [OFF_W-1:0]    gather_offset,
    output logic                gather_insert,
    output logic                gather_type,
    output logic [GCNT_W-1:0]   gather_count,
    output logic [WORD_W-1:0]   gather_addr,
    output logic                lock_valid,
    output logic                lock_release,
    output logic [LOCK_W-1:0]   lock_index,
    output logic                ext_unknown,
    output logic                bad_opcode
);
    state_e             state, state_nxt;
    hdr_t               hdr;
    logic [CLASS_W-1:0] cur_class;
    logic [OFF_W-1:0]   cur_off;
    logic [CNT_W-1:0]   remain;
    logic [MASK_W-1:0]  mask_reg;
    logic [IDX_W-1:0]   walk_idx;
    logic [MASK_W-1:0]  walk_rest;
    logic               accept;

    cmdsd_hdr_split u_split (
        .word (in_word),
        .hdr  (hdr)
    );

    cmdsd_mask_walk #(.W(MASK_W)) u_walk (
        .mask (mask_reg),
        .idx  (walk_idx),
        .rest (walk_rest)
    );

    assign in_ready = !wr_valid || wr_ready;
    assign accept   = in_valid && in_ready;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HEADER: begin
                if (accept) begin
                    case (hdr.opc)
                        OPC_SETCL:   state_nxt = (hdr.smask != '0) ? ST_MASKED  : ST_HEADER;
                        OPC_INCR:    state_nxt = (hdr.cnt   != '0) ? ST_INCR    : ST_HEADER;
                        OPC_NONINCR: state_nxt = (hdr.cnt   != '0) ? ST_NONINCR : ST_HEADER;
                        OPC_MASK:    state_nxt = (hdr.mask  != '0) ? ST_MASKED  : ST_HEADER;
                        OPC_GATHER:  state_nxt = ST_GATHER;
                        default:     state_nxt = ST_HEADER;
                    endcase
                end
            end
            ST_INCR, ST_NONINCR: begin
                if (accept && remain == CNT_W'(1)) state_nxt = ST_HEADER;
            end
            ST_MASKED: begin
                if (accept && walk_rest == '0) state_nxt = ST_HEADER;
            end
            ST_GATHER: begin
                if (accept) state_nxt = ST_HEADER;
            end
            default: state_nxt = ST_HEADER;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HEADER;
        else        state <= state_nxt;
    end

    // Outputs and tracked context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_class     <= '0;
            cur_off       <= '0;
            remain        <= '0;
            mask_reg      <= '0;
            wr_valid      <= 1'b0;
            wr_class      <= '0;
            wr_offset     <= '0;
            wr_data       <= '0;
            restart_valid <= 1'b0;
            restart_addr  <= '0;
            gather_valid  <= 1'b0;
            gather_offset <= '0;
            gather_insert <= 1'b0;
            gather_type   <= 1'b0;
            gather_count  <= '0;
            gather_addr   <= '0;
            lock_valid    <= 1'b0;
            lock_release  <= 1'b0;
            lock_index    <= '0;
            ext_unknown   <= 1'b0;
            bad_opcode    <= 1'b0;
        end else begin
            restart_valid <= 1'b0;
            gather_valid  <= 1'b0;
            lock_valid    <= 1'b0;
            ext_unknown   <= 1'b0;
            bad_opcode    <= 1'b0;
            if (wr_valid && wr_ready) wr_valid <= 1'b0;

            if (accept) begin
                unique case (state)
                    ST_HEADER: begin
                        case (hdr.opc)
                            OPC_SETCL: begin
                                cur_class <= hdr.cls;
                                cur_off   <= hdr.off;
                                mask_reg  <= MASK_W'(hdr.smask);
                            end
                            OPC_INCR, OPC_NONINCR: begin
                                cur_off <= hdr.off;
                                remain  <= hdr.cnt;
                            end
                            OPC_MASK: begin
                                cur_off  <= hdr.off;
                                mask_reg <= hdr.mask;
                            end
                            OPC_IMM: begin
                                wr_valid  <= 1'b1;
                                wr_class  <= cur_class;
                                wr_offset <= hdr.off;
                                wr_data   <= WORD_W'(hdr.cnt);
                            end
                            OPC_RESTART: begin
                                restart_valid <= 1'b1;
                                restart_addr  <= {in_word[WORD_W-5:0], 4'b0000};
                            end
                            OPC_GATHER: begin
                                gather_offset <= hdr.off;
                                gather_insert <= hdr.g_ins;
                                gather_type   <= hdr.g_type;
                                gather_count  <= hdr.g_cnt;
                            end
                            OPC_EXTEND: begin
                                if (hdr.sub == SUB_ACQUIRE || hdr.sub == SUB_RELEASE) begin
                                    lock_valid   <= 1'b1;
                                    lock_release <= (hdr.sub == SUB_RELEASE);
                                    lock_index   <= hdr.lock;
                                end else begin
                                    ext_unknown <= 1'b1;
                                end
                            end
                            default: bad_opcode <= 1'b1;
                        endcase
                    end
                    ST_INCR: begin
                        wr_valid  <= 1'b1;
                        wr_class  <= cur_class;
                        wr_offset <= cur_off;
                        wr_data   <= in_word;
                        cur_off   <= cur_off + OFF_W'(1);
                        remain    <= remain - CNT_W'(1);
                    end
                    ST_NONINCR: begin
                        wr_valid  <= 1'b1;
                        wr_class  <= cur_class;
                        wr_offset <= cur_off;
                        wr_data   <= in_word;
                        remain    <= remain - CNT_W'(1);
                    end
                    ST_MASKED: begin
                        wr_valid  <= 1'b1;
                        wr_class  <= cur_class;
                        wr_offset <= cur_off + OFF_W'(walk_idx);
                        wr_data   <= in_word;
                        mask_reg  <= walk_rest;
                    end
                    ST_GATHER: begin
                        gather_valid <= 1'b1;
                        gather_addr  <= in_word;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Assertions
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_class) && $stable(wr_offset) && $stable(wr_data)); // R12
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |-> !in_ready); // R12
    AST_SIDE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({restart_valid, gather_valid, lock_valid, ext_unknown, bad_opcode})); // R13
    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_MASKED |-> $countones(mask_reg) > 0); // R5
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INCR || state == ST_NONINCR) |-> remain != '0); // R10
    AST_BAD_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bad_opcode |-> state == ST_HEADER); // R11
    AST_GATHER_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_GATHER && accept |=> state == ST_HEADER && gather_valid); // R8
endmodule

// File: tb/test_cmd_stream_decoder.sv
module test_cmd_stream_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        restart_valid;
    logic [31:0] restart_addr;
    logic        gather_valid;
    logic [11:0] gather_offset;
    logic        gather_insert;
    logic        gather_type;
    logic [13:0] gather_count;
    logic [31:0] gather_addr;
    logic        lock_valid;
    logic        lock_release;
    logic [7:0]  lock_index;
    logic        ext_unknown;
    logic        bad_opcode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic       rand_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    localparam logic [2:0] K_RST = 3'd1, K_GAT = 3'd2, K_ACQ = 3'd3,
                           K_REL = 3'd4, K_UNK = 3'd5, K_BAD = 3'd6;

    logic [53:0] wq[$];
    string       wtag[$];
    logic [66:0] sq[$];
    string       stag[$];
    logic [9:0]  m_class = '0;

    cmd_stream_decoder i_cmd_stream_decoder (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rand_ready) wr_ready <= lfsr[3] | lfsr[7];
    end

    task automatic chk(input bit ok, input string tag, input logic [66:0] act, input logic [66:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write monitor with stall tracking
    logic        was_stall = 1'b0;
    logic [53:0] held;
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (was_stall) begin
                chk(wr_valid && {wr_class, wr_offset, wr_data} == held, "R12 hold",
                    67'({wr_valid, wr_class, wr_offset, wr_data}), 67'({1'b1, held}));
            end
            if (wr_valid && !wr_ready) begin
                chk(!in_ready, "R12 in_ready", 67'(in_ready), 67'(0));
                held = {wr_class, wr_offset, wr_data};
                was_stall = 1'b1;
            end else was_stall = 1'b0;
            if (wr_valid && wr_ready) begin
                if (wq.size() == 0) chk(0, "write unexpected", 67'({wr_class, wr_offset, wr_data}), 67'(0));
                else begin
                    logic [53:0] e;
                    string t;
                    e = wq.pop_front();
                    t = wtag.pop_front();
                    chk({wr_class, wr_offset, wr_data} == e, t, 67'({wr_class, wr_offset, wr_data}), 67'(e));
                end
            end
            if (restart_valid | gather_valid | lock_valid | ext_unknown | bad_opcode) begin
                logic [66:0] o;
                if (restart_valid)     o = {K_RST, restart_addr, 32'd0};
                else if (gather_valid) o = {K_GAT, gather_addr, 4'd0, gather_offset, gather_insert, gather_type, gather_count};
                else if (lock_valid)   o = {lock_release ? K_REL : K_ACQ, 24'd0, lock_index, 32'd0};
                else if (ext_unknown)  o = {K_UNK, 64'd0};
                else                   o = {K_BAD, 64'd0};
                if (sq.size() == 0) chk(0, "side unexpected", o, 67'(0));
                else begin
                    logic [66:0] e;
                    string t;
                    e = sq.pop_front();
                    t = stag.pop_front();
                    chk(o == e, t, o, e);
                end
            end
        end
    end

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic exp_wr(input logic [11:0] off, input logic [31:0] d, input string t);
        wq.push_back({m_class, off, d});
        wtag.push_back(t);
    endtask

    task automatic t_incr(input bit inc, input logic [11:0] off, input int n, input logic [31:0] db, input string t);
        send({inc ? 4'd1 : 4'd2, off, 16'(n)});
        for (int i = 0; i < n; i++) begin
            exp_wr(inc ? off + 12'(i) : off, db + 32'(i), t);
            send(db + 32'(i));
        end
    endtask

    task automatic t_mask(input logic [11:0] off, input logic [15:0] m, input logic [31:0] db, input string t);
        int k = 0;
        send({4'd3, off, m});
        for (int b = 0; b < 16; b++) begin
            if (m[b]) begin
                exp_wr(off + 12'(b), db + 32'(k), t);
                send(db + 32'(k));
                k++;
            end
        end
    endtask

    task automatic t_setcl(input logic [9:0] c, input logic [11:0] off, input logic [5:0] m, input logic [31:0] db);
        int k = 0;
        send({4'd0, off, c, m});
        m_class = c;
        for (int b = 0; b < 6; b++) begin
            if (m[b]) begin
                exp_wr(off + 12'(b), db + 32'(k), "R2 setclass payload");
                send(db + 32'(k));
                k++;
            end
        end
    endtask

    task automatic t_imm(input logic [11:0] off, input logic [15:0] d, input string t);
        exp_wr(off, {16'd0, d}, t);
        send({4'd4, off, d});
    endtask

    task automatic exp_side(input logic [66:0] e, input string t);
        sq.push_back(e);
        stag.push_back(t);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(!wr_valid && in_ready, "R1 reset wr_valid/in_ready", 67'({wr_valid, in_ready}), 67'({1'b0, 1'b1}));
        chk({restart_valid, gather_valid, lock_valid, ext_unknown, bad_opcode} == 5'd0,
            "R1 reset side-band", 67'({restart_valid, gather_valid, lock_valid, ext_unknown, bad_opcode}), 67'(0));
        rst_n = 1'b1;

        t_incr(1, 12'h010, 3, 32'h1000_0000, "R1 R3 incr class0");
        t_setcl(10'h155, 12'h020, 6'b100101, 32'h2000_0000);
        send({4'd0, 12'h000, 10'h0AA, 6'd0});
        m_class = 10'h0AA;
        t_imm(12'h7FF, 16'hBEEF, "R2 R6 zero-mask class then imm");
        // R13 write latency
        exp_wr(12'h055, 32'h0000_1234, "R6 imm");
        send({4'd4, 12'h055, 16'h1234});
        chk(wr_valid && wr_data == 32'h1234, "R13 write next cycle", 67'({wr_valid, wr_data}), 67'({1'b1, 32'h1234}));
        t_incr(0, 12'h040, 4, 32'h3000_0000, "R4 nonincr");
        t_mask(12'h100, 16'h8421, 32'h4000_0000, "R5 sparse mask");
        t_mask(12'h200, 16'hFFFF, 32'h5000_0000, "R5 full mask");
        // R10 zero count / zero mask
        send({4'd1, 12'h300, 16'd0});
        t_imm(12'h301, 16'h0001, "R10 after zero incr");
        send({4'd2, 12'h300, 16'd0});
        t_imm(12'h302, 16'h0002, "R10 after zero nonincr");
        send({4'd3, 12'h300, 16'd0});
        t_imm(12'h303, 16'h0003, "R10 after zero mask");
        // R7 restart with R13 latency
        exp_side({K_RST, 32'hABCD_EF10, 32'd0}, "R7 restart");
        send(32'h5ABC_DEF1);
        chk(restart_valid, "R13 restart pulse next cycle", 67'(restart_valid), 67'(1));
        @(posedge clk);
        #1;
        chk(!restart_valid, "R13 restart pulse one cycle", 67'(restart_valid), 67'(0));
        // R8 gather
        exp_side({K_GAT, 32'hDEAD_0000, 4'd0, 12'h123, 1'b1, 1'b0, 14'h2A5}, "R8 gather");
        send({4'd6, 12'h123, 1'b1, 1'b0, 14'h2A5});
        send(32'hDEAD_0000);
        t_imm(12'h004, 16'h0044, "R8 header after gather");
        // R9 extend
        exp_side({K_ACQ, 24'd0, 8'h17, 32'd0}, "R9 acquire");
        send({4'd14, 4'd0, 16'd0, 8'h17});
        exp_side({K_REL, 24'd0, 8'h3C, 32'd0}, "R9 release");
        send({4'd14, 4'd1, 16'd0, 8'h3C});
        exp_side({K_UNK, 64'd0}, "R9 unknown sub");
        send({4'd14, 4'd7, 16'd0, 8'h01});
        t_imm(12'h009, 16'h0009, "R9 header after extend");
        // R11 unused opcodes
        exp_side({K_BAD, 64'd0}, "R11 opcode 7");
        send(32'h7000_0003);
        t_imm(12'h00B, 16'h000B, "R11 after opcode 7");
        exp_side({K_BAD, 64'd0}, "R11 opcode 15");
        send(32'hF000_0002);
        t_imm(12'h00C, 16'h000C, "R11 after opcode 15");
        // R12 back-pressure, incr wrap
        rand_ready = 1'b1;
        t_incr(1, 12'hFFE, 20, 32'h6000_0000, "R3 R12 wrap under stall");
        t_mask(12'h0F0, 16'h0A0F, 32'h7000_0000, "R5 R12 mask under stall");
        t_setcl(10'h3FF, 12'h010, 6'b111111, 32'h8000_0000);
        rand_ready = 1'b0;
        @(posedge clk);
        #1;
        wr_ready = 1'b1;
        repeat (10) @(posedge clk);
        #2;
        chk(wq.size() == 0, "R12 all writes delivered", 67'(wq.size()), 67'(0));
        chk(sq.size() == 0, "R13 all side-band events seen", 67'(sq.size()), 67'(0));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule